// File: doc/BRIEF.md
# Cascadable Master Serial Output Sequencer

This block sends the results of a four-channel sampling device over a shared serial bus. It runs as bus master and is clocked only by the master clock. It holds one 22-bit result per channel. Each result is loaded through a valid/ready input port and placed at the top of a 32-bit word whose low bits are zero. A rising cascade token starts a frame. The block drops an active-low data-ready flag, enables its serial clock, frame sync and data outputs, and shifts out all four words, one bit per master clock. When the frame ends it releases the three bus outputs to high impedance and raises a two-clock cascade-out pulse.

Several devices can be chained: each cascade-out drives the next cascade-in. The devices then take turns on one bus, and no two of them drive it at the same time. The serial clock is the master clock, gated by the output enable. Data changes on its rising edge, so a receiver samples on the falling edge.

Back-pressure on the input port works as follows. `in_ready` is high only while the sequencer is idle. A word set is captured on a clock edge where `in_valid` and `in_ready` are both high. While a frame or its cascade pulse is in progress, `in_ready` is low, any asserted `in_valid` is dropped, and the held results stay as they were.

Top module: `casc_seq`

## Requirements
- R1: After reset `drdy_n` is 1, `sclk_oe`, `rfs_oe` and `sdata_oe` are 0, `casc_out` is 0, `in_ready` is 1, and all held results are zero.
- R2: `in_ready` is 1 exactly when the sequencer is idle. On an edge with `in_valid` and `in_ready` both high, channel k's result is taken from `in_data[22k+21:22k]`. An `in_valid` seen while `in_ready` is 0 leaves the held results unchanged.
- R3: If `casc_in` is seen rising at an idle clock edge, then at the next edge `drdy_n` goes to 0 and `sclk_oe`, `rfs_oe` and `sdata_oe` go to 1, giving one clock of setup.
- R4: `rfs` is 1 with `rfs_oe` for exactly the first bit cycle of a frame, and 0 for the remaining bit cycles.
- R5: A frame is 128 bit cycles, one bit per master clock. Channel 0's word goes first and channel 3's last, each from bit 31 down to bit 0. `sdata` updates on the rising clock edge.
- R6: Each 32-bit word is the 22-bit result in bits 31:10, with bits 9:0 zero.
- R7: At the edge after the last bit cycle, the three output enables drop to 0 and `drdy_n` returns to 1.
- R8: At that same edge `casc_out` rises. It stays high for exactly two master clocks, and then the block is idle.
- R9: A rising `casc_in` while the block is not idle is ignored. A `casc_in` held high never starts a second frame.
- R10: With two devices chained, the bus carries eight words in order (device A channels 0 to 3, then device B channels 0 to 3), and the two devices never enable their data outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Result set offered |
| in_ready | output | 1 | Result set accepted this edge (idle only) |
| in_data | input | 88 | Four 22-bit results, channel 0 in the low bits |
| casc_in | input | 1 | Cascade token input; a rising level starts a frame |
| drdy_n | output | 1 | Data-ready flag, low during the bit cycles |
| sclk | output | 1 | Serial clock, the master clock while enabled, else high impedance |
| sclk_oe | output | 1 | Serial clock drive enable |
| rfs | output | 1 | Frame sync, high impedance when disabled |
| rfs_oe | output | 1 | Frame sync drive enable |
| sdata | output | 1 | Serial data, high impedance when disabled |
| sdata_oe | output | 1 | Serial data drive enable |
| casc_out | output | 1 | Two-clock token pulse to the next device |

## Verification
The hardest situations to reach from the ports are the ones where a token or an input word arrives while the device is busy. This means a second `casc_in` rise during the bit cycles or during the cascade pulse, a `casc_in` held high well past the end of the frame, and `in_valid` raised while `in_ready` is low. Each of these has to leave the frame untouched. The stimulus places these events at random offsets inside chained frames. It then checks every cycle of both devices against a timeline computed from the cascade start. It also reassembles the merged bus, so a retrigger, an overlap or a corrupted word shows up as a misplaced bit or an overlap count.

// File: rtl/casc_seq_pkg.sv
package casc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_SEND = 2'd2,
    ST_PASS = 2'd3
  } seq_state_e;
endpackage

// File: rtl/casc_word_bank.sv
module casc_word_bank #(
  parameter int NUM_CH = 4,
  parameter int RES_W  = 22,
  parameter int WORD_W = 32,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int PAD_W = WORD_W - RES_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_en,
  input  logic [NUM_CH*RES_W-1:0] load_data,
  input  logic [CH_W-1:0]         ch_sel,
  output logic [WORD_W-1:0]       word_o
);
  logic [RES_W-1:0] res_q [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)       res_q[ch] <= '0;
      else if (load_en) res_q[ch] <= load_data[ch*RES_W +: RES_W];
    end
  end

  // Result sits at the top of the word; spare low bits read as zero.
  if (PAD_W > 0) begin : g_pad
    assign word_o = {res_q[ch_sel], {PAD_W{1'b0}}};
  end else begin : g_nopad
    assign word_o = res_q[ch_sel];
  end
endmodule

// File: rtl/casc_bit_pick.sv
module casc_bit_pick #(
  parameter int WORD_W = 32,
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [BIT_W-1:0]  bit_sel,
  output logic              bit_o
);
  // bit_sel counts from the MSB downwards.
  assign bit_o = word_i[BIT_W'(WORD_W-1) - bit_sel];
endmodule

// File: rtl/casc_frame_ctrl.sv
module casc_frame_ctrl
  import casc_seq_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int WORD_W   = 32,
  parameter int PASS_LEN = 2,
  localparam int TOTAL   = NUM_CH * WORD_W,
  localparam int CNT_W   = $clog2(TOTAL),
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int BIT_W   = $clog2(WORD_W),
  localparam int PASS_W  = (PASS_LEN > 1) ? $clog2(PASS_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             casc_in,
  output logic             idle_o,
  output logic             drdy_n_o,
  output logic             tx_en_o,
  output logic             rfs_o,
  output logic             casc_out_o,
  output logic [CH_W-1:0]  ch_sel_o,
  output logic [BIT_W-1:0] bit_sel_o
);
  seq_state_e        state;
  logic              casc_q;
  logic [CNT_W-1:0]  cnt;
  logic [PASS_W-1:0] pass_cnt;
  logic              token_rise;

  assign token_rise = casc_in && !casc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      casc_q   <= 1'b0;
      cnt      <= '0;
      pass_cnt <= '0;
    end else begin
      casc_q <= casc_in;
      unique case (state)
        ST_IDLE: if (token_rise) state <= ST_ARM;
        ST_ARM: begin
          state <= ST_SEND;
          cnt   <= '0;
        end
        ST_SEND: begin
          if (cnt == CNT_W'(TOTAL - 1)) begin
            state    <= ST_PASS;
            pass_cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PASS: begin
          if (pass_cnt == PASS_W'(PASS_LEN - 1)) state <= ST_IDLE;
          else pass_cnt <= pass_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign idle_o     = (state == ST_IDLE);
  assign tx_en_o    = (state == ST_SEND);
  assign drdy_n_o   = (state != ST_SEND);
  assign rfs_o      = (state == ST_SEND) && (cnt == '0);
  assign casc_out_o = (state == ST_PASS);
  assign ch_sel_o   = CH_W'(32'(cnt) / WORD_W);
  assign bit_sel_o  = BIT_W'(32'(cnt) % WORD_W);
endmodule

// File: rtl/casc_seq.sv
module casc_seq #(
  parameter int NUM_CH   = 4,
  parameter int RES_W    = 22,
  parameter int WORD_W   = 32,
  parameter int PASS_LEN = 2,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int BIT_W   = $clog2(WORD_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [NUM_CH*RES_W-1:0] in_data,
  input  logic                    casc_in,
  output logic                    drdy_n,
  output logic                    sclk,
  output logic                    sclk_oe,
  output logic                    rfs,
  output logic                    rfs_oe,
  output logic                    sdata,
  output logic                    sdata_oe,
  output logic                    casc_out
);
  logic              idle;
  logic              tx_en;
  logic              rfs_act;
  logic [CH_W-1:0]   ch_sel;
  logic [BIT_W-1:0]  bit_sel;
  logic [WORD_W-1:0] cur_word;
  logic              cur_bit;

  casc_frame_ctrl #(
    .NUM_CH(NUM_CH), .WORD_W(WORD_W), .PASS_LEN(PASS_LEN)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .casc_in(casc_in),
    .idle_o(idle), .drdy_n_o(drdy_n), .tx_en_o(tx_en),
    .rfs_o(rfs_act), .casc_out_o(casc_out),
    .ch_sel_o(ch_sel), .bit_sel_o(bit_sel)
  );

  casc_word_bank #(
    .NUM_CH(NUM_CH), .RES_W(RES_W), .WORD_W(WORD_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .load_en(in_valid && in_ready),
    .load_data(in_data), .ch_sel(ch_sel), .word_o(cur_word)
  );

  casc_bit_pick #(.WORD_W(WORD_W)) u_pick (
    .word_i(cur_word), .bit_sel(bit_sel), .bit_o(cur_bit)
  );

  assign in_ready = idle;
  assign sclk_oe  = tx_en;
  assign rfs_oe   = tx_en;
  assign sdata_oe = tx_en;
  assign sclk     = sclk_oe  ? clk     : 1'bz;
  assign rfs      = rfs_oe   ? rfs_act : 1'bz;
  assign sdata    = sdata_oe ? cur_bit : 1'bz;
endmodule

// File: rtl/casc_seq_chk.sv
module casc_seq_chk #(
  parameter int TOTAL_BITS = 128,
  parameter int PASS_LEN   = 2
) (
  input logic clk,
  input logic rst_n,
  input logic drdy_n,
  input logic rfs_act,
  input logic sdata_oe,
  input logic sclk_oe,
  input logic rfs_oe,
  input logic casc_out,
  input logic in_ready
);
  int unsigned low_cnt;
  int unsigned hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt <= 0;
      hi_cnt  <= 0;
    end else begin
      low_cnt <= drdy_n   ? 0 : low_cnt + 1;
      hi_cnt  <= casc_out ? hi_cnt + 1 : 0;
    end
  end

  // R3
  frame_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_n) |-> (rfs_act && sdata_oe && sclk_oe && rfs_oe));

  // R4
  rfs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfs_act |=> !rfs_act);

  // R5
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_n) |-> (low_cnt == TOTAL_BITS));

  // R7
  frame_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_n) |-> (casc_out && !sdata_oe && !sclk_oe && !rfs_oe));

  // R8
  token_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(casc_out) |-> (hi_cnt == PASS_LEN));

  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!drdy_n || casc_out) |-> !in_ready);
endmodule

bind casc_seq casc_seq_chk #(
  .TOTAL_BITS(NUM_CH * WORD_W), .PASS_LEN(PASS_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .drdy_n(drdy_n), .rfs_act(rfs_act),
  .sdata_oe(sdata_oe), .sclk_oe(sclk_oe), .rfs_oe(rfs_oe),
  .casc_out(casc_out), .in_ready(in_ready)
);

// File: tb/casc_seq_tb.sv
`timescale 1ns/1ps
module casc_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        a_valid = 1'b0, b_valid = 1'b0;
  logic [87:0] a_data = '0, b_data = '0;
  logic        casc_a = 1'b0;
  wire         a_ready, a_drdy_n, a_sclk, a_sclk_oe, a_rfs, a_rfs_oe, a_sdata, a_sdata_oe, a_casc_out;
  wire         b_ready, b_drdy_n, b_sclk, b_sclk_oe, b_rfs, b_rfs_oe, b_sdata, b_sdata_oe, b_casc_out;

  casc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(a_valid), .in_ready(a_ready), .in_data(a_data),
    .casc_in(casc_a), .drdy_n(a_drdy_n), .sclk(a_sclk), .sclk_oe(a_sclk_oe),
    .rfs(a_rfs), .rfs_oe(a_rfs_oe), .sdata(a_sdata), .sdata_oe(a_sdata_oe), .casc_out(a_casc_out));

  casc_seq u_dut_b (
    .clk(clk), .rst_n(rst_n), .in_valid(b_valid), .in_ready(b_ready), .in_data(b_data),
    .casc_in(a_casc_out), .drdy_n(b_drdy_n), .sclk(b_sclk), .sclk_oe(b_sclk_oe),
    .rfs(b_rfs), .rfs_oe(b_rfs_oe), .sdata(b_sdata), .sdata_oe(b_sdata_oe), .casc_out(b_casc_out));

  int checks = 0;
  int errors = 0;
  logic [21:0] exp_res [2][4];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int d, input int i);
    logic [31:0] w;
    w = {exp_res[d][i / 32], 10'b0};
    return w[31 - (i % 32)];
  endfunction

  function automatic logic [31:0] exp_word(input int d, input int ch);
    return {exp_res[d][ch], 10'b0};
  endfunction

  // Check one device against the timeline; arm = cycle its start edge occurred.
  task automatic check_dev(input int d, input int t, input int arm);
    logic drdy, ready, sc_oe, rf_oe, rf, sd_oe, sd, co;
    bit   send;
    int   i;
    drdy  = d == 0 ? a_drdy_n   : b_drdy_n;
    ready = d == 0 ? a_ready    : b_ready;
    sc_oe = d == 0 ? a_sclk_oe  : b_sclk_oe;
    rf_oe = d == 0 ? a_rfs_oe   : b_rfs_oe;
    rf    = d == 0 ? a_rfs      : b_rfs;
    sd_oe = d == 0 ? a_sdata_oe : b_sdata_oe;
    sd    = d == 0 ? a_sdata    : b_sdata;
    co    = d == 0 ? a_casc_out : b_casc_out;
    send  = (t >= arm + 1) && (t <= arm + 128);
    i     = t - arm - 1;
    chk("R3/R7/R9 drdy_n", 32'(drdy), 32'(!send));
    chk("R3/R7 sclk_oe", 32'(sc_oe), 32'(send));
    chk("R3/R7 sdata_oe", 32'(sd_oe), 32'(send));
    chk("R3/R7 rfs_oe", 32'(rf_oe), 32'(send));
    if (send) begin
      chk("R4 rfs", 32'(rf), 32'(i == 0));
      chk("R5 sdata bit", 32'(sd), 32'(exp_bit(d, i)));
    end
    chk("R8 casc_out", 32'(co), 32'((t >= arm + 129) && (t <= arm + 130)));
    chk("R2 in_ready", 32'(ready), 32'(!((t >= arm) && (t <= arm + 130))));
  endtask

  task automatic load(input logic [87:0] da, input logic [87:0] db);
    @(negedge clk);
    chk("R2 ready idle A", 32'(a_ready), 32'd1);
    chk("R2 ready idle B", 32'(b_ready), 32'd1);
    a_valid = 1'b1; a_data = da;
    b_valid = 1'b1; b_data = db;
    for (int ch = 0; ch < 4; ch++) begin
      exp_res[0][ch] = da[ch*22 +: 22];
      exp_res[1][ch] = db[ch*22 +: 22];
    end
    @(negedge clk);
    a_valid = 1'b0; b_valid = 1'b0;
  endtask

  task automatic run_frame(input int width, input int pulse_t, input int junk_t);
    int   nbits;
    int   overlap;
    logic got [256];
    logic [31:0] w;
    nbits = 0; overlap = 0;
    @(negedge clk);
    casc_a = 1'b1;
    for (int t = 0; t < 265; t++) begin
      @(negedge clk);
      check_dev(0, t, 0);
      check_dev(1, t, 130);
      if (a_sdata_oe && b_sdata_oe) overlap++;
      if (a_sdata_oe || b_sdata_oe) begin
        if (nbits < 256) got[nbits] = a_sdata_oe ? a_sdata : b_sdata;
        nbits++;
      end
      if (t == width - 1) casc_a = 1'b0;
      if (t == pulse_t) casc_a = 1'b1;
      if (t == pulse_t + 1) casc_a = 1'b0;
      if (t == junk_t) begin
        a_valid = 1'b1;
        a_data  = {$urandom, $urandom, $urandom};
      end
      if (t == junk_t + 1) a_valid = 1'b0;
    end
    chk("R10 overlap", 32'(overlap), 32'd0);
    chk("R10 bit count", 32'(nbits), 32'd256);
    for (int k = 0; k < 8; k++) begin
      for (int b = 0; b < 32; b++) w[31 - b] = (k * 32 + b < 256) ? got[k * 32 + b] : 1'b0;
      chk("R6/R10 word", w, exp_word(k / 4, k % 4));
    end
  endtask

  function automatic logic [87:0] rand_set();
    logic [87:0] v;
    for (int ch = 0; ch < 4; ch++) v[ch*22 +: 22] = 22'($urandom);
    return v;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int d = 0; d < 2; d++)
      for (int ch = 0; ch < 4; ch++) exp_res[d][ch] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 drdy_n", 32'(a_drdy_n), 32'd1);
    chk("R1 oe", 32'({a_sclk_oe, a_rfs_oe, a_sdata_oe, b_sclk_oe, b_rfs_oe, b_sdata_oe}), 32'd0);
    chk("R1 casc_out", 32'({a_casc_out, b_casc_out}), 32'd0);
    chk("R1 in_ready", 32'({a_ready, b_ready}), 32'd3);
    run_frame(1, -10, -10);                       // R1 zero results after reset
    load({4{22'h3FFFFF}}, {4{22'h2AAAAA}});       // R6 corner patterns
    run_frame(2, -10, -10);
    load({22'h000001, 22'h200000, 22'h155555, 22'h0}, rand_set());
    run_frame(1, 130, -10);                       // R9 token during cascade pulse
    run_frame(140, -10, 40);                      // R9 held token, R2 load while busy
    for (int n = 0; n < 6; n++) begin
      load(rand_set(), rand_set());
      run_frame(1 + int'($urandom % 4), 5 + int'($urandom % 126), 2 + int'($urandom % 119));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule